// File: doc/BRIEF.md
# Floating-Point Min/Max and Ordered Compare Unit

This block is a purely combinational datapath that takes two IEEE-754 binary operands (binary64 by default) and, under a 3-bit operation code, returns either the smaller or larger of the two, or a 0/1 answer to an ordered less-than or less-or-equal question. It sits behind an operand read stage and ahead of a writeback stage. It holds no state and needs no clock.

Two families of min/max are offered. The standard family hides a single NaN by returning the other operand. The NaN-propagating family returns the canonical quiet NaN as soon as either input is a NaN. Comparisons come in a signaling flavour, which raises the invalid flag for any NaN input, and a quiet flavour, which raises it only for signaling NaNs. The exception vector keeps the usual five-flag layout, but only the invalid bit can ever be set.

The exponent and fraction widths are parameters, so the same unit can be built for narrower formats.

Top module: `fp_minmax_cmp`

## Requirements
- R1: Operation codes 3'b000 (min) and 3'b001 (max), with two non-NaN operands, return the numerically smaller or larger operand bit for bit. This holds across sign changes, infinities and subnormals.
- R2: In all four min/max codes, -0.0 ranks below +0.0. Min of the pair gives -0.0 and max gives +0.0, whatever the operand order.
- R3: Codes 3'b000/3'b001 with exactly one NaN operand return the other operand unchanged. With two NaN operands they return the canonical NaN (sign 0, exponent all ones, only the fraction MSB set; 64'h7FF8_0000_0000_0000 for binary64).
- R4: Codes 3'b010 (NaN-propagating min) and 3'b011 (NaN-propagating max) return the canonical NaN when at least one operand is a NaN. Otherwise they give the same result as 3'b000/3'b001.
- R5: Compare codes are 3'b100 (less-than, signaling), 3'b101 (less-or-equal, signaling), 3'b110 (less-than, quiet) and 3'b111 (less-or-equal, quiet). The answer is in result bit 0 and all other result bits are 0. -0.0 and +0.0 compare equal.
- R6: Any compare with at least one NaN operand returns 0.
- R7: Signaling compares (3'b100, 3'b101) set the invalid flag, flags bit 4, whenever either operand is a NaN, quiet or signaling.
- R8: For all other codes, the invalid flag is set only when an operand is a signaling NaN: exponent all ones, fraction non-zero, fraction MSB 0. A quiet NaN alone leaves flags bit 4 at 0.
- R9: Flags bits 3:0 (divide-by-zero, overflow, underflow, inexact) are always 0.
- R10: The format follows EXP_W and MAN_W. With EXP_W=5 and MAN_W=10, the canonical NaN is 16'h7E00 and all rules above apply to 16-bit operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (see R1, R4, R5) |
| opnd_a | input | EXP_W+MAN_W+1 | First operand |
| opnd_b | input | EXP_W+MAN_W+1 | Second operand |
| result | output | EXP_W+MAN_W+1 | Selected value or 0/1 compare answer |
| flags | output | 5 | Exception flags; bit 4 invalid, bits 3:0 always 0 |

## Verification
The bench builds two copies of the unit. The first uses the default binary64 widths (EXP_W=11, MAN_W=52) and carries all the directed scenarios. The second uses EXP_W=5, MAN_W=10, which puts the half-width canonical NaN and the narrow-format signaling-NaN detection within reach. That copy checks that the derived constants and field slicing follow the parameters rather than fixed binary64 positions.

// File: rtl/fpmm_pkg.sv
// Shared types for the min/max/compare unit.
// Assumes: operation codes are fixed by the requirements and decoded by bit.
package fpmm_pkg;

    typedef enum logic [2:0] {
        OP_MIN   = 3'b000,
        OP_MAX   = 3'b001,
        OP_MINP  = 3'b010,
        OP_MAXP  = 3'b011,
        OP_LT_S  = 3'b100,
        OP_LE_S  = 3'b101,
        OP_LT_Q  = 3'b110,
        OP_LE_Q  = 3'b111
    } fpmm_op_e;

    // Per-operand classification produced by fp_classify
    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_snan;
        logic is_zero;
    } fp_class_t;

    localparam int FLAG_W       = 5;
    localparam int FLAG_INVALID = 4;

endpackage

// File: rtl/fp_classify.sv
// Classifies one IEEE-754 operand: sign, NaN, signaling NaN, zero.
// Assumes: standard layout {sign, exponent, fraction}, quiet bit = fraction MSB.
module fp_classify
    import fpmm_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    localparam int W     = EXP_W + MAN_W + 1
) (
    input  logic [W-1:0] val,
    output fp_class_t    cls
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    // Slice fields and derive the class bits
    always_comb begin
        exp_f       = val[W-2:MAN_W];
        man_f       = val[MAN_W-1:0];
        cls.sign    = val[W-1];
        cls.is_nan  = (&exp_f) && (|man_f);
        cls.is_snan = (&exp_f) && (|man_f) && !man_f[MAN_W-1];
        cls.is_zero = (exp_f == '0) && (man_f == '0);
    end

endmodule

// File: rtl/fp_order.sv
// Orders two non-NaN operands with one shared magnitude comparator.
// tot_lt ranks -0 below +0 (min/max use); cmp_lt/cmp_eq follow IEEE
// compare rules where the zeros are equal. NaN handling is left to callers.
module fp_order
    import fpmm_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    localparam int W     = EXP_W + MAN_W + 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  fp_class_t    cls_a,
    input  fp_class_t    cls_b,
    output logic         tot_lt,
    output logic         cmp_lt,
    output logic         cmp_eq
);

    logic mag_lt, mag_gt, both_zero;

    // Unsigned compare of exponent+fraction orders magnitudes
    always_comb begin
        mag_lt = a[W-2:0] < b[W-2:0];
        mag_gt = a[W-2:0] > b[W-2:0];
    end

    // Apply sign to get a total order, then IEEE zero fix-up
    always_comb begin
        both_zero = cls_a.is_zero && cls_b.is_zero;
        if (cls_a.sign != cls_b.sign)
            tot_lt = cls_a.sign;
        else if (cls_a.sign)
            tot_lt = mag_gt;
        else
            tot_lt = mag_lt;
        cmp_lt = tot_lt && !both_zero;
        cmp_eq = (a == b) || both_zero;
    end

endmodule

// File: rtl/fp_pick.sv
// Chooses the min/max result, including both NaN policies.
// Assumes: tot_lt is valid whenever neither operand is a NaN.
module fp_pick
    import fpmm_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    localparam int W     = EXP_W + MAN_W + 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  fp_class_t    cls_a,
    input  fp_class_t    cls_b,
    input  logic         tot_lt,
    input  logic         want_max,
    input  logic         nan_prop,
    output logic [W-1:0] pick
);

    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic any_nan, both_nan, take_b;

    // Select the operand or the canonical NaN
    always_comb begin
        any_nan  = cls_a.is_nan || cls_b.is_nan;
        both_nan = cls_a.is_nan && cls_b.is_nan;
        take_b   = want_max ? tot_lt : !tot_lt;
        if (both_nan || (nan_prop && any_nan))
            pick = CANON_NAN;
        else if (cls_a.is_nan)
            pick = b;
        else if (cls_b.is_nan)
            pick = a;
        else
            pick = take_b ? b : a;
    end

endmodule

// File: rtl/fp_minmax_cmp.sv
// Top: combinational min/max and ordered compare for one FP format.
// Assumes: op_sel encodings per fpmm_pkg; no state, no clock.
module fp_minmax_cmp
    import fpmm_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [2:0]             op_sel,
    input  logic [EXP_W+MAN_W:0]   opnd_a,
    input  logic [EXP_W+MAN_W:0]   opnd_b,
    output logic [EXP_W+MAN_W:0]   result,
    output logic [FLAG_W-1:0]      flags
);

    localparam int W = EXP_W + MAN_W + 1;

    logic [W-1:0] opnd [2];
    fp_class_t    cls  [2];

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    // One classifier per operand
    for (genvar i = 0; i < 2; i++) begin : g_cls
        fp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val (opnd[i]),
            .cls (cls[i])
        );
    end

    logic tot_lt, cmp_lt, cmp_eq;

    fp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
        .a      (opnd[0]),
        .b      (opnd[1]),
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .tot_lt (tot_lt),
        .cmp_lt (cmp_lt),
        .cmp_eq (cmp_eq)
    );

    logic is_cmp, cmp_quiet, cmp_le, any_nan, any_snan;
    logic [W-1:0] mm_val;

    // Decode the operation code by field
    always_comb begin
        is_cmp    = op_sel[2];
        cmp_quiet = op_sel[1];
        cmp_le    = op_sel[0];
        any_nan   = cls[0].is_nan || cls[1].is_nan;
        any_snan  = cls[0].is_snan || cls[1].is_snan;
    end

    fp_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pick (
        .a        (opnd[0]),
        .b        (opnd[1]),
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .tot_lt   (tot_lt),
        .want_max (op_sel[0]),
        .nan_prop (op_sel[1]),
        .pick     (mm_val)
    );

    logic cmp_bit, invalid;

    // Form the compare answer and the invalid flag
    always_comb begin
        cmp_bit = !any_nan && (cmp_le ? (cmp_lt || cmp_eq) : cmp_lt);
        if (is_cmp && !cmp_quiet)
            invalid = any_nan;
        else
            invalid = any_snan;
    end

    // Drive outputs
    always_comb begin
        result = is_cmp ? {{(W-1){1'b0}}, cmp_bit} : mm_val;
        flags  = '0;
        flags[FLAG_INVALID] = invalid;
    end

endmodule

// File: rtl/fp_minmax_cmp_chk.sv
// Checker for fp_minmax_cmp: relates ports through independent decoding.
// Assumes: a combinational unit, so checks are immediate and re-evaluated on input change.
module fp_minmax_cmp_chk #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input logic [2:0]           op_sel,
    input logic [EXP_W+MAN_W:0] opnd_a,
    input logic [EXP_W+MAN_W:0] opnd_b,
    input logic [EXP_W+MAN_W:0] result,
    input logic [4:0]           flags
);

    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] CANON =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic a_nan, b_nan, a_sn, b_sn;

    // Port-level NaN decoding and property checks
    always_comb begin
        a_nan = (&opnd_a[W-2:MAN_W]) && (|opnd_a[MAN_W-1:0]);
        b_nan = (&opnd_b[W-2:MAN_W]) && (|opnd_b[MAN_W-1:0]);
        a_sn  = a_nan && !opnd_a[MAN_W-1];
        b_sn  = b_nan && !opnd_b[MAN_W-1];

        a_r1_minmax_member: assert (op_sel[2] || a_nan || b_nan ||
                                    result == opnd_a || result == opnd_b)
            else $error("minmax result not an operand");
        a_r3_single_nan_passes: assert (!(op_sel[2:1] == 2'b00 && a_nan && !b_nan) ||
                                        result == opnd_b)
            else $error("single NaN not bypassed");
        a_r4_prop_canonical: assert (!(op_sel[2:1] == 2'b01 && (a_nan || b_nan)) ||
                                     result == CANON)
            else $error("propagating minmax missed canonical NaN");
        a_r5_cmp_boolean: assert (!op_sel[2] || result[W-1:1] == '0)
            else $error("compare result not boolean");
        a_r6_nan_cmp_false: assert (!(op_sel[2] && (a_nan || b_nan)) || result == '0)
            else $error("compare with NaN returned true");
        a_r7_sig_invalid: assert (!(op_sel[2:1] == 2'b10 && (a_nan || b_nan)) || flags[4])
            else $error("signaling compare missed invalid");
        a_r8_quiet_no_invalid: assert (op_sel[2:1] == 2'b10 || a_sn || b_sn || !flags[4])
            else $error("invalid raised without signaling NaN");
    end

endmodule

bind fp_minmax_cmp fp_minmax_cmp_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result),
    .flags  (flags)
);

// File: tb/fp_minmax_cmp_test.sv
module fp_minmax_cmp_test;

    localparam logic [2:0] MIN = 3'b000, MAX = 3'b001, MINP = 3'b010, MAXP = 3'b011;
    localparam logic [2:0] LTS = 3'b100, LES = 3'b101, LTQ = 3'b110, LEQ = 3'b111;

    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] MONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PZ    = 64'h0;
    localparam logic [63:0] NZ    = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] DEN   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] CANON = 64'h7FF8_0000_0000_0000;
    localparam logic [4:0]  NV    = 5'b10000;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [2:0]  op_sel = 3'b000;
    logic [63:0] opnd_a = '0, opnd_b = '0, result;
    logic [4:0]  flags;

    logic [2:0]  h_op = 3'b000;
    logic [15:0] h_a = '0, h_b = '0, h_res;
    logic [4:0]  h_flags;

    int checks = 0, errors = 0;
    bit done = 0;

    fp_minmax_cmp uut (
        .op_sel (op_sel), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .result (result), .flags (flags)
    );

    fp_minmax_cmp #(.EXP_W(5), .MAN_W(10)) uut_h (
        .op_sel (h_op), .opnd_a (h_a), .opnd_b (h_b),
        .result (h_res), .flags (h_flags)
    );

    task automatic apply(input string req, input logic [2:0] op,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] exp_res, input logic [4:0] exp_fl);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        #5;
        checks++;
        if (result !== exp_res) begin
            errors++;
            $display("FAIL %s result op=%b got %h expected %h", req, op, result, exp_res);
        end
        checks++;
        if (flags !== exp_fl) begin
            errors++;
            $display("FAIL %s/R9 flags op=%b got %b expected %b", req, op, flags, exp_fl);
        end
    endtask

    task automatic apply_h(input string req, input logic [2:0] op,
                           input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] exp_res, input logic [4:0] exp_fl);
        @(negedge clk);
        h_op = op; h_a = a; h_b = b;
        #5;
        checks++;
        if (h_res !== exp_res || h_flags !== exp_fl) begin
            errors++;
            $display("FAIL %s half op=%b got %h/%b expected %h/%b",
                     req, op, h_res, h_flags, exp_res, exp_fl);
        end
    endtask

    task automatic t_idle();
        apply("R1 idle", MIN, PZ, PZ, PZ, 5'b0);
    endtask

    task automatic t_plain_minmax();
        apply("R1", MIN, ONE, TWO, ONE, 5'b0);
        apply("R1", MAX, ONE, TWO, TWO, 5'b0);
        apply("R1", MIN, MONE, TWO, MONE, 5'b0);
        apply("R1", MAX, MTWO, MONE, MONE, 5'b0);
        apply("R1", MIN, NINF, DEN, NINF, 5'b0);
        apply("R1", MAX, PINF, ONE, PINF, 5'b0);
        apply("R4", MINP, TWO, ONE, ONE, 5'b0);
        apply("R4", MAXP, MONE, DEN, DEN, 5'b0);
    endtask

    task automatic t_signed_zero();
        apply("R2", MIN, PZ, NZ, NZ, 5'b0);
        apply("R2", MAX, NZ, PZ, PZ, 5'b0);
        apply("R2", MINP, NZ, PZ, NZ, 5'b0);
        apply("R2", MAXP, PZ, NZ, PZ, 5'b0);
    endtask

    task automatic t_std_nan();
        apply("R3", MIN, QNAN, TWO, TWO, 5'b0);
        apply("R3", MAX, ONE, QNAN, ONE, 5'b0);
        apply("R3", MIN, QNAN, QNAN, CANON, 5'b0);
        apply("R3/R8", MAX, SNAN, ONE, ONE, NV);
        apply("R3/R8", MIN, SNAN, QNAN, CANON, NV);
    endtask

    task automatic t_prop_nan();
        apply("R4", MINP, QNAN, ONE, CANON, 5'b0);
        apply("R4/R8", MAXP, ONE, SNAN, CANON, NV);
        apply("R4", MAXP, QNAN, QNAN, CANON, 5'b0);
    endtask

    task automatic t_compare();
        apply("R5", LTS, ONE, TWO, 64'd1, 5'b0);
        apply("R5", LTS, TWO, ONE, 64'd0, 5'b0);
        apply("R5", LES, ONE, ONE, 64'd1, 5'b0);
        apply("R5", LES, NZ, PZ, 64'd1, 5'b0);
        apply("R5", LTS, NZ, PZ, 64'd0, 5'b0);
        apply("R5", LTQ, MONE, ONE, 64'd1, 5'b0);
        apply("R5", LEQ, TWO, ONE, 64'd0, 5'b0);
        apply("R5", LTS, MTWO, MONE, 64'd1, 5'b0);
    endtask

    task automatic t_compare_nan();
        apply("R6/R7", LTS, QNAN, ONE, 64'd0, NV);
        apply("R6/R7", LES, ONE, QNAN, 64'd0, NV);
        apply("R6/R8", LTQ, QNAN, ONE, 64'd0, 5'b0);
        apply("R6/R8", LEQ, SNAN, ONE, 64'd0, NV);
        apply("R6/R8", LEQ, QNAN, QNAN, 64'd0, 5'b0);
    endtask

    task automatic t_half_format();
        apply_h("R10", MINP, 16'h3C00, 16'h7C01, 16'h7E00, NV);
        apply_h("R10", MIN, 16'h3C00, 16'h4000, 16'h3C00, 5'b0);
        apply_h("R10", LTQ, 16'hBC00, 16'h3C00, 16'h0001, 5'b0);
        apply_h("R10", MAX, 16'h7E00, 16'h7E00, 16'h7E00, 5'b0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_plain_minmax();
        t_signed_zero();
        t_std_nan();
        t_prop_nan();
        t_compare();
        t_compare_nan();
        t_half_format();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule